// File: doc/BRIEF.md
# Daisy-Chained Converter Serial Port (Busy-Flag Chain Mode)

This block is the digital side of one 16-bit sampling converter whose serial output can be wired to the serial input of the next converter, so that several converters share one three-wire host port. The host starts a conversion by raising the convert line while the serial clock is high. The block runs a conversion timer of a fixed number of system clock cycles. When the timer expires, it captures the result word from the converter model. Once the upstream neighbour reports that it is ready, the block raises its serial output. On the last device in the chain, that rising output tells the host that every converter has finished.

The host then reads the chain like one long shift register. The first serial-clock falling edge after the ready flag arms readback. Each later falling edge moves one bit toward the host, most significant bit first. The bit arriving on the serial input is pulled into the bottom of the local word. For N devices the host issues 16·N+1 falling edges. The three pins are asynchronous to the system clock, so the block synchronises them and acts only on detected edges.

Top module: `chain_adc_port`

## Requirements
- R1: After reset, and whenever the synchronised convert line is low, SDO is low, whatever SDI and SCK do.
- R2: A rising edge on the convert line while SCK is high starts a conversion. A rising edge while SCK is low starts nothing, and SDO stays low even when SDI goes high afterwards.
- R3: During the conversion, which lasts CONV_CYCLES system clock cycles, SDO is low and SCK edges have no effect on the word that is read back later.
- R4: After the conversion ends, SDO stays low while SDI is low, and goes high (the ready flag) once SDI is high.
- R5: The first SCK falling edge after the ready flag puts result bit 15 on SDO. Each further falling edge presents the next lower bit, ending with bit 0 after the 16th edge.
- R6: On every SCK falling edge after the first, the SDI level is shifted into the bottom of the word. After falling edges 17 to 32, SDO therefore shows the upstream bits that were on SDI at falling edges 2 to 17, in order.
- R7: A falling edge on the convert line in any phase returns the block to idle with SDO low. A later convert rise with SCK high starts a fresh conversion.
- R8: The result word is sampled when the conversion ends. Changes on the result input after that point do not alter the bits read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Convert line from host (asynchronous) |
| sck_i | input | 1 | Serial clock from host (asynchronous) |
| sdi_i | input | 1 | Serial input from upstream device (asynchronous) |
| result_i | input | DATA_W | Parallel result from the converter model |
| sdo_o | output | 1 | Serial output: ready flag, then chain data |

## Verification
The hardest situation to reach is the wait after conversion in which the local device has finished but its upstream neighbour has not. In that window SDO must stay low despite a valid captured word. The bench plays the upstream neighbour on SDI: it holds SDI low well past the conversion, checks that SDO stays low, and only then raises SDI. The bench also toggles SCK during conversion and changes the result input after capture. Readback must still deliver the original word.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CONV,
        PH_WAIT_UP,
        PH_READY,
        PH_SHIFT
    } phase_e;

    localparam int PIN_CNV  = 0;
    localparam int PIN_SCK  = 1;
    localparam int PIN_SDI  = 2;
    localparam int NUM_PINS = 3;

    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic done
);
    import chain_adc_pkg::*;
    localparam int CNT_W = cnt_bits(CONV_CYCLES);

    logic [CNT_W-1:0] cnt;
    logic             running;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            cnt     <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else if (start) begin
            cnt     <= CNT_W'(CONV_CYCLES - 1);
            running <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= running && (cnt == '0);
            if (running) begin
                if (cnt == '0) running <= 1'b0;
                else           cnt     <= cnt - 1'b1;
            end
        end
    end

    // R2: the end-of-conversion strobe never follows a start directly
    p_no_instant_done_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !abort && CONV_CYCLES > 1) |=> !done);
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              shift,
    input  logic              sin,
    output logic              msb
);
    logic [DATA_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst)        word <= '0;
        else if (load)  word <= din;
        else if (shift) word <= {word[DATA_W-2:0], sin};
    end

    assign msb = word[DATA_W-1];

    // R6: the serial input lands in the bottom bit on each shift
    p_sin_at_lsb_r6: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (word[0] == $past(sin)));
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo_o
);
    import chain_adc_pkg::*;

    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pins_lvl;
    logic [1:0]          pins_prev;

    assign pins_raw[PIN_CNV] = cnv_i;
    assign pins_raw[PIN_SCK] = sck_i;
    assign pins_raw[PIN_SDI] = sdi_i;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_sync
        pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pins_raw[g]),
            .q   (pins_lvl[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) pins_prev <= '0;
        else     pins_prev <= {pins_lvl[PIN_SCK], pins_lvl[PIN_CNV]};
    end

    logic cnv_lvl, sck_lvl, sdi_lvl;
    logic cnv_rise, cnv_fall, sck_fall;
    assign cnv_lvl  = pins_lvl[PIN_CNV];
    assign sck_lvl  = pins_lvl[PIN_SCK];
    assign sdi_lvl  = pins_lvl[PIN_SDI];
    assign cnv_rise = cnv_lvl && !pins_prev[0];
    assign cnv_fall = !cnv_lvl && pins_prev[0];
    assign sck_fall = !sck_lvl && pins_prev[1];

    phase_e phase, phase_nx;
    logic   conv_start, conv_done, arm_shift;

    always_comb begin
        phase_nx   = phase;
        conv_start = 1'b0;
        arm_shift  = 1'b0;
        if (cnv_fall) begin
            phase_nx = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (cnv_rise && sck_lvl) begin
                    phase_nx   = PH_CONV;
                    conv_start = 1'b1;
                end
                PH_CONV:    if (conv_done) phase_nx = PH_WAIT_UP;
                PH_WAIT_UP: if (sdi_lvl)   phase_nx = PH_READY;
                PH_READY:   if (sck_fall)  phase_nx = PH_SHIFT;
                PH_SHIFT:   arm_shift = sck_fall;
                default:    phase_nx  = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (conv_start),
        .abort (cnv_fall),
        .done  (conv_done)
    );

    logic word_msb;
    logic capture;
    assign capture = (phase == PH_CONV) && conv_done && !cnv_fall;

    word_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (capture),
        .din   (result_i),
        .shift (arm_shift),
        .sin   (sdi_lvl),
        .msb   (word_msb)
    );

    assign sdo_o = (phase == PH_READY) || ((phase == PH_SHIFT) && word_msb);

    // R1: a low convert line forces SDO low on the next cycle
    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !cnv_lvl |=> !sdo_o);

    // R2: a conversion is only ever entered with SCK high
    p_start_needs_sck_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_CONV) |-> $past(sck_lvl));

    // R3: no data leaves the device while converting
    p_conv_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV) |-> !sdo_o);

    // R4: ready flag withheld until upstream reports ready
    p_wait_upstream_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT_UP && !sdi_lvl) |=> !sdo_o);

    // R5: first falling edge after the flag exposes the captured top bit
    p_first_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READY && sck_fall && !cnv_fall) |=> (sdo_o == $past(word_msb)));
endmodule

// File: tb/tb_chain_adc_port.sv
module tb_chain_adc_port;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int CONV = 40;
    localparam int NVEC = 4;
    localparam logic [31:0] VEC [NVEC] = '{
        32'hA5C3_1E0F, 32'hFFFF_0000, 32'h0001_8000, 32'h7E81_5A5A
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnv = 1'b0, sck = 1'b1, sdi = 1'b0;
    logic [DW-1:0] res = '0;
    logic sdo;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_adc_port #(.DATA_W(DW), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
        .result_i(res), .sdo_o(sdo)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: sdo=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic fall_rise();
        step(4); sck = 1'b0; step(8);
    endtask

    initial begin
        step(5);
        check(sdo, 1'b0, "R1 reset");
        rst = 1'b0;
        step(5);
        // R1: convert low, SDI high, SCK toggling
        sdi = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; step(8); check(sdo, 1'b0, "R1 idle"); sck = 1'b1; step(8);
        end
        sdi = 1'b0;

        // R2: rise with SCK low starts nothing
        sck = 1'b0; step(8); cnv = 1'b1; step(CONV + 20);
        sdi = 1'b1; step(10);
        check(sdo, 1'b0, "R2 sck-low start");
        cnv = 1'b0; sdi = 1'b0; sck = 1'b1; step(10);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] rw, up;
            rw = VEC[v][31:16]; up = VEC[v][15:0];
            res = rw; sdi = 1'b0; sck = 1'b1; step(8);
            cnv = 1'b1; step(6);
            check(sdo, 1'b0, "R3 converting");
            step(CONV + 10);
            check(sdo, 1'b0, "R4 upstream busy");
            step(20);
            check(sdo, 1'b0, "R4 upstream still busy");
            sdi = 1'b1; step(8);
            check(sdo, 1'b1, "R4 ready flag");
            for (int f = 1; f <= 32; f++) begin
                if (f >= 2 && f <= 17) sdi = up[17-f];
                else if (f > 17)       sdi = 1'b0;
                fall_rise();
                if (f <= 16) check(sdo, rw[16-f], "R5 local bit");
                else         check(sdo, up[32-f], "R6 upstream bit");
                sck = 1'b1; step(8);
            end
            cnv = 1'b0; step(8);
            check(sdo, 1'b0, "R7 end of read");
        end

        // R3 + R8: SCK activity during conversion, result changes after capture
        res = 16'hC35A; sdi = 1'b0; sck = 1'b1; step(8);
        cnv = 1'b1; step(6);
        for (int i = 0; i < 2; i++) begin
            sck = 1'b0; step(6); check(sdo, 1'b0, "R3 sck ignored"); sck = 1'b1; step(6);
        end
        step(CONV + 10);
        res = 16'h3CA5;
        sdi = 1'b1; step(8);
        check(sdo, 1'b1, "R3 flag after conv");
        fall_rise(); check(sdo, 1'b1, "R8 bit15 kept"); sck = 1'b1; step(8);
        fall_rise(); check(sdo, 1'b1, "R8 bit14 kept"); sck = 1'b1; step(8);
        fall_rise(); check(sdo, 1'b0, "R8 bit13 kept"); sck = 1'b1; step(8);

        // R7: abort mid-read, then restart
        cnv = 1'b0; step(8);
        check(sdo, 1'b0, "R7 abort in shift");
        res = 16'h8000; step(4); cnv = 1'b1; step(CONV + 12);
        check(sdo, 1'b1, "R7 restart flag");
        cnv = 1'b0; step(8);
        check(sdo, 1'b0, "R7 abort in ready");

        $display("%0d/%0d checks passed", checks - fails, checks);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule